// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides what a single memory access may do once the page entry for its address has been found. It combines the entry's two-bit protection field, its extra protection bit and its no-execute bit with the segment's supervisor and user key bits, the current privilege level and the access direction. From these it produces read, write and execute grants and a fault flag. A one-cycle strobe starts an evaluation. One clock later the registered results appear, together with a one-cycle valid pulse.

A single configurable special page sits beside the table-based decision. While the core runs in supervisor state, an access whose effective page number equals the configured special effective page bypasses the table entirely. That access receives full read, write and execute rights, a 4 KB page size and a real address built from the configured special physical page. In problem (user) state, or while the special effective address is zero, the override is off.

Top module: `pgperm_check`

## Requirements
- R1: The key bit is 1 when `prob_st`=1 and `seg_kp`=1, or when `prob_st`=0 and `seg_ks`=1; otherwise it is 0.
- R2: The protection index is 4 bits: bits [1:0] are `pte_pp`, bit 2 is the key bit of R1, and bit 3 is `pte_pp0`.
- R3: Without override, `may_wr` is 1 exactly when the index is 0, 1, 2 or 6.
- R4: Without override, `may_rd` is 1 exactly when the index is 0, 1, 2, 3, 5, 6, 7 or 10; every other index grants neither read nor write.
- R5: Without override, `may_ex` is the inverse of `pte_nx`, except that it is forced to 1 when `prob_st`=0 and `nx_off`=1.
- R6: Without override, `perm_fault` is 1 when read is not granted, or when `acc_wr`=1 and write is not granted.
- R7: The override applies when `spc_ea` is nonzero, `req_ea` and `spc_ea` agree in every bit from 12 upward, and `prob_st`=0. It then gives `may_rd`=`may_wr`=`may_ex`=1, `perm_fault`=0 and `out_psz`=0 (4 KB), whatever the entry and key inputs are.
- R8: Under override, `out_ra` = `spc_pa` OR `req_ea[11:0]`. Without override, `out_ra` is 0 and `out_psz` repeats `pte_psz` (code 0 = 4 KB, 1 = 64 KB, 2 = 16 MB).
- R9: `out_vld` pulses for exactly one cycle, one clock after each `req_vld` cycle. All result outputs hold their values while `req_vld` is low.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Evaluation strobe |
| req_ea | input | EA_W | Effective address of the access |
| pte_pp | input | 2 | Page entry protection field |
| pte_pp0 | input | 1 | Page entry extra protection bit |
| pte_nx | input | 1 | Page entry no-execute bit |
| pte_psz | input | 2 | Page size code of the matched entry |
| seg_ks | input | 1 | Segment supervisor key |
| seg_kp | input | 1 | Segment problem-state key |
| prob_st | input | 1 | Processor is in problem (user) state |
| nx_off | input | 1 | Ignore no-execute in supervisor state |
| acc_wr | input | 1 | Access is a write |
| spc_ea | input | EA_W | Special page effective address (0 = off) |
| spc_pa | input | RA_W | Special page physical address |
| out_vld | output | 1 | Result valid pulse |
| may_rd | output | 1 | Read granted |
| may_wr | output | 1 | Write granted |
| may_ex | output | 1 | Execute granted |
| perm_fault | output | 1 | Permission fault |
| out_psz | output | 2 | Resulting page size code |
| out_ra | output | RA_W | Real address under override, else 0 |

## Verification
The table path is driven through all 128 combinations of protection field, extra bit, both keys, privilege and access direction. This separates the key selection by privilege from the index decode and from the write-fault condition. No-execute and its supervisor disable are varied inside the same sweep.

Override stimuli are built to tell apart each of the three enabling conditions. They include a zero special address against page zero, a user-state access to the special page, an address that differs only at bit 12, and addresses that differ only below bit 12. The last of these also checks how the real address is assembled.

A final idle stretch with changing inputs shows that the outputs hold their values between strobes.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  localparam int unsigned PP_W   = 2;
  localparam int unsigned IDX_W  = PP_W + 2;
  localparam int unsigned NIDX   = 1 << IDX_W;
  localparam int unsigned PSZ_W  = 2;

  typedef enum logic [PSZ_W-1:0] {
    PSZ_4K  = 2'd0,
    PSZ_64K = 2'd1,
    PSZ_16M = 2'd2
  } psz_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic fault;
  } perm_t;
endpackage

// File: rtl/pgperm_index.sv
module pgperm_index
  import pgperm_pkg::*;
(
  input  logic [PP_W-1:0]  pp,
  input  logic             pp0,
  input  logic             ks,
  input  logic             kp,
  input  logic             prob,
  output logic [IDX_W-1:0] idx
);
  logic key;

  // user state consults the problem key, supervisor the supervisor key
  always_comb begin
    key = prob ? kp : ks;
    idx = {pp0, key, pp};
  end
endmodule

// File: rtl/pgperm_decode.sv
module pgperm_decode #(
  parameter int unsigned IW = 4,
  parameter logic [(1<<IW)-1:0] WR_SET = 16'h0047,
  parameter logic [(1<<IW)-1:0] RD_SET = 16'h04EF
) (
  input  logic [IW-1:0] idx,
  output logic          rd_ok,
  output logic          wr_ok
);
  always_comb begin
    rd_ok = RD_SET[idx];
    wr_ok = WR_SET[idx];
  end
endmodule

// File: rtl/pgperm_special.sv
module pgperm_special #(
  parameter int unsigned EA_W  = 48,
  parameter int unsigned RA_W  = 48,
  parameter int unsigned OFS_W = 12
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] sp_ea,
  input  logic [RA_W-1:0] sp_pa,
  input  logic            prob,
  output logic            hit,
  output logic [RA_W-1:0] ra
);
  localparam int unsigned PN_W = EA_W - OFS_W;

  logic armed;
  logic pg_eq;

  always_comb begin
    armed = |sp_ea;
    pg_eq = (ea[EA_W-1:OFS_W] == sp_ea[EA_W-1:OFS_W]);
    hit   = armed && pg_eq && !prob;
    ra    = sp_pa | {{(RA_W-OFS_W){1'b0}}, ea[OFS_W-1:0]};
  end

  logic [PN_W-1:0] unused_pn;
  assign unused_pn = '0;
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
  import pgperm_pkg::*;
#(
  parameter int unsigned EA_W  = 48,
  parameter int unsigned RA_W  = 48,
  parameter int unsigned OFS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [EA_W-1:0] req_ea,
  input  logic [1:0]      pte_pp,
  input  logic            pte_pp0,
  input  logic            pte_nx,
  input  logic [1:0]      pte_psz,
  input  logic            seg_ks,
  input  logic            seg_kp,
  input  logic            prob_st,
  input  logic            nx_off,
  input  logic            acc_wr,
  input  logic [EA_W-1:0] spc_ea,
  input  logic [RA_W-1:0] spc_pa,
  output logic            out_vld,
  output logic            may_rd,
  output logic            may_wr,
  output logic            may_ex,
  output logic            perm_fault,
  output logic [1:0]      out_psz,
  output logic [RA_W-1:0] out_ra
);
  localparam logic [NIDX-1:0] WR_SET = NIDX'((1 << 0) | (1 << 1) | (1 << 2) | (1 << 6));
  localparam logic [NIDX-1:0] RD_SET = WR_SET | NIDX'((1 << 3) | (1 << 5) | (1 << 7) | (1 << 10));

  logic [IDX_W-1:0] idx;
  logic             tbl_rd, tbl_wr;
  logic             ovr_hit;
  logic [RA_W-1:0]  ovr_ra;

  pgperm_index u_idx (
    .pp   (pte_pp),
    .pp0  (pte_pp0),
    .ks   (seg_ks),
    .kp   (seg_kp),
    .prob (prob_st),
    .idx  (idx)
  );

  pgperm_decode #(.IW(IDX_W), .WR_SET(WR_SET), .RD_SET(RD_SET)) u_dec (
    .idx   (idx),
    .rd_ok (tbl_rd),
    .wr_ok (tbl_wr)
  );

  pgperm_special #(.EA_W(EA_W), .RA_W(RA_W), .OFS_W(OFS_W)) u_spc (
    .ea    (req_ea),
    .sp_ea (spc_ea),
    .sp_pa (spc_pa),
    .prob  (prob_st),
    .hit   (ovr_hit),
    .ra    (ovr_ra)
  );

  // next-state
  perm_t           perm_d, perm_q;
  logic [1:0]      psz_d, psz_q;
  logic [RA_W-1:0] ra_d, ra_q;
  logic            vld_q;
  logic            tbl_ex;

  always_comb begin
    tbl_ex = !pte_nx || (!prob_st && nx_off);
    if (ovr_hit) begin
      perm_d = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, fault: 1'b0};
      psz_d  = PSZ_4K;
      ra_d   = ovr_ra;
    end else begin
      perm_d.rd    = tbl_rd;
      perm_d.wr    = tbl_wr;
      perm_d.ex    = tbl_ex;
      perm_d.fault = !tbl_rd || (acc_wr && !tbl_wr);
      psz_d        = pte_psz;
      ra_d         = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= '0;
      psz_q  <= '0;
      ra_q   <= '0;
    end else if (req_vld) begin
      perm_q <= perm_d;
      psz_q  <= psz_d;
      ra_q   <= ra_d;
    end
  end

  assign out_vld    = vld_q;
  assign may_rd     = perm_q.rd;
  assign may_wr     = perm_q.wr;
  assign may_ex     = perm_q.ex;
  assign perm_fault = perm_q.fault;
  assign out_psz    = psz_q;
  assign out_ra     = ra_q;

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld);

  // R9
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !out_vld);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(perm_q) && $stable(out_psz) && $stable(out_ra));

  // R7
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ovr_hit) |=> (may_rd && may_wr && may_ex && !perm_fault && out_psz == 2'd0));

  // R7
  ovr_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |-> !prob_st);

  // R4
  wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && may_wr |-> may_rd);

  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && perm_fault |-> !(may_rd && may_wr));
endmodule

// File: tb/pgperm_check_test.sv
`timescale 1ns/1ps
module pgperm_check_test;
  localparam int EA_W = 48;
  localparam int RA_W = 48;

  typedef struct packed {
    logic rd; logic wr; logic ex; logic fault;
    logic [1:0] psz; logic [RA_W-1:0] ra;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_vld;
  logic [EA_W-1:0] req_ea;
  logic [1:0] pte_pp, pte_psz;
  logic pte_pp0, pte_nx, seg_ks, seg_kp, prob_st, nx_off, acc_wr;
  logic [EA_W-1:0] spc_ea;
  logic [RA_W-1:0] spc_pa;
  logic out_vld, may_rd, may_wr, may_ex, perm_fault;
  logic [1:0] out_psz;
  logic [RA_W-1:0] out_ra;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t exp_q[$];
  exp_t last_exp;

  always #2.5 clk = ~clk;

  pgperm_check #(.EA_W(EA_W), .RA_W(RA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ea(req_ea),
    .pte_pp(pte_pp), .pte_pp0(pte_pp0), .pte_nx(pte_nx), .pte_psz(pte_psz),
    .seg_ks(seg_ks), .seg_kp(seg_kp), .prob_st(prob_st), .nx_off(nx_off),
    .acc_wr(acc_wr), .spc_ea(spc_ea), .spc_pa(spc_pa), .out_vld(out_vld),
    .may_rd(may_rd), .may_wr(may_wr), .may_ex(may_ex), .perm_fault(perm_fault),
    .out_psz(out_psz), .out_ra(out_ra)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    logic key, wok, rok, hit;
    logic [3:0] idx;
    key = (prob_st && seg_kp) || (!prob_st && seg_ks);       // R1
    idx = {pte_pp0, key, pte_pp};                             // R2
    wok = (idx == 0) || (idx == 1) || (idx == 2) || (idx == 6);
    rok = wok || (idx == 3) || (idx == 5) || (idx == 7) || (idx == 10);
    hit = (spc_ea != 0) && (req_ea[EA_W-1:12] == spc_ea[EA_W-1:12]) && !prob_st;
    if (hit) begin
      e.rd = 1; e.wr = 1; e.ex = 1; e.fault = 0; e.psz = 2'd0;
      e.ra = spc_pa | RA_W'(req_ea[11:0]);
    end else begin
      e.rd = rok; e.wr = wok;
      e.ex = !pte_nx || (!prob_st && nx_off);
      e.fault = !rok || (acc_wr && !wok);
      e.psz = pte_psz; e.ra = '0;
    end
    return e;
  endfunction

  // driver: called at a negedge, returns at the next negedge
  task automatic send();
    exp_t e;
    e = model();
    req_vld = 1'b1;
    exp_q.push_back(e);
    last_exp = e;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(may_wr == e.wr, "R3 write grant", 64'(may_wr), 64'(e.wr));
        chk(may_rd == e.rd, "R4 read grant", 64'(may_rd), 64'(e.rd));
        chk(may_ex == e.ex, "R5 execute grant", 64'(may_ex), 64'(e.ex));
        chk(perm_fault == e.fault, "R6 fault", 64'(perm_fault), 64'(e.fault));
        chk(out_psz == e.psz, "R7/R8 page size", 64'(out_psz), 64'(e.psz));
        chk(out_ra == e.ra, "R8 real address", 64'(out_ra), 64'(e.ra));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_ea = '0; pte_pp = '0; pte_psz = '0;
    pte_pp0 = 0; pte_nx = 0; seg_ks = 0; seg_kp = 0; prob_st = 0; nx_off = 0;
    acc_wr = 0; spc_ea = 48'h0000_5555_3000; spc_pa = 48'h0000_0ABC_D000;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({out_vld, may_rd, may_wr, may_ex, perm_fault} == 5'b0, "R10 reset flags",
        64'({out_vld, may_rd, may_wr, may_ex, perm_fault}), 0);
    chk(out_psz == 0 && out_ra == 0, "R10 reset data", 64'(out_ra), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table sweep: R1 R2 R3 R4 R5 R6
    for (int c = 0; c < 128; c++) begin
      pte_pp  = c[1:0];
      pte_pp0 = c[2];
      seg_ks  = c[3];
      seg_kp  = c[4];
      prob_st = c[5];
      acc_wr  = c[6];
      pte_nx  = c[1] ^ c[4];
      nx_off  = c[2] ^ c[6];
      pte_psz = 2'(c % 3);
      req_ea  = 48'h0012_3400_0000 + 48'(c * 4096) + 48'(c);
      send();
    end

    // override cases R7 R8
    pte_pp = 2'd3; pte_pp0 = 1; seg_ks = 1; seg_kp = 1; pte_nx = 1; nx_off = 0;
    acc_wr = 1; pte_psz = 2'd2;
    prob_st = 0; req_ea = 48'h0000_5555_3ABC; send();    // hit, low bits differ
    prob_st = 0; req_ea = 48'h0000_5555_3000; send();    // exact hit
    prob_st = 1; req_ea = 48'h0000_5555_3ABC; send();    // user state: no override
    prob_st = 0; req_ea = 48'h0000_5555_2ABC; send();    // bit 12 differs
    spc_ea = '0; prob_st = 0; req_ea = 48'h0000_0000_0123; send(); // disabled at page 0
    spc_ea = 48'h0000_0000_0FFF; spc_pa = 48'h0000_0000_7001;
    req_ea = 48'h0000_0000_0FFE; send();                 // nonzero low-only special
    req_vld = 1'b0;

    // R9 hold: change inputs without a strobe
    pte_pp = 2'd0; pte_pp0 = 0; seg_ks = 0; prob_st = 1; pte_psz = 2'd1;
    req_ea = 48'h0000_0000_9000;
    repeat (4) @(negedge clk);
    chk(out_vld == 0, "R9 no pulse without strobe", 64'(out_vld), 0);
    chk({may_rd, may_wr, may_ex, perm_fault} == {last_exp.rd, last_exp.wr, last_exp.ex, last_exp.fault},
        "R9 held grants", 64'({may_rd, may_wr, may_ex, perm_fault}),
        64'({last_exp.rd, last_exp.wr, last_exp.ex, last_exp.fault}));
    chk(out_ra == last_exp.ra, "R9 held address", 64'(out_ra), 64'(last_exp.ra));
    chk(exp_q.size() == 0, "R9 all results seen", 64'(exp_q.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule